// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block is a passive observer for an asynchronous DRAM port. It receives the five active-low strobes: the row strobe, an upper-byte and a lower-byte column strobe, write enable and output enable. Each strobe passes through a multi-flop synchroniser on a fast local clock. The block then works out from the order of the strobe edges what kind of access is taking place. It issues one event when a row cycle ends (refresh cycles) or when a column sub-cycle ends (reads and writes). Each event carries a 4-bit type, a byte-lane mask and two error flags.

Typical uses are a protocol checker next to a DRAM controller, or the decode stage of a behavioural memory model. The event output is a plain one-cycle valid pulse with no ready input. The observed bus cannot be stalled, so the block applies no back-pressure and any consumer must accept every pulse.

Type encoding: 0 no event, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh, 7 hidden refresh. Bit 3 is set on column sub-cycles after the first one within the same row cycle (page access). In the lane mask, bit 0 is the lower byte and bit 1 is the upper byte.

Top module: `dram_cycle_classifier`

## Requirements
- R1: During and after reset, evt_valid is 0 and evt_type reads 0 until a strobe sequence completes; evt_type also reads 0 in any cycle without an event.
- R2: An event is presented in the clock cycle that follows the second rising clock edge after the first edge that samples the strobe change ending the cycle, and lasts one clock.
- R3: A row cycle in which neither column strobe is active is reported when the row strobe returns high, as type 5 with lane mask 0 and no error flags.
- R4: If either column strobe (even one alone) was already active in the sample before the row strobe falls, the row cycle is reported as type 6 when the row strobe rises.
- R5: A column strobe that falls in the same synchronised sample as the row strobe starts a normal access, not a refresh.
- R6: A column sub-cycle with write enable inactive throughout is type 1. If write enable is active in the sample where the first column strobe falls, or earlier, the sub-cycle is type 2.
- R7: If write enable becomes active after the first column strobe fell, the sub-cycle is type 4 when output enable was active at that column fall, and type 3 otherwise. Once a write type has been chosen it does not change within the sub-cycle.
- R8: A sub-cycle spans from the earlier column-strobe fall to the later column-strobe rise. Its lane mask holds every lane that was active during it.
- R9: Within one row cycle, the second and later sub-cycles set bit 3 of the type.
- R10: If the row strobe goes high after a read while the column strobes stay active, and then falls again, that row cycle is type 7. The read itself is reported as type 1 when the column strobes release.
- R11: evt_mode_err is set on a sub-cycle where a lane joins late with a write-enable level different from the one at the sub-cycle start.
- R12: evt_lane_err is set on a sub-cycle where a lane that was active goes inactive and then active again before the sub-cycle ends.
- R13: When a refresh event and a sub-cycle end fall on the same sample, the refresh is presented first and the sub-cycle event on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| evt_valid | output | 1 | One-cycle event pulse, no back-pressure |
| evt_type | output | 4 | Event type code, 0 when no event |
| evt_lanes | output | 2 | Lane mask: bit 0 lower, bit 1 upper |
| evt_mode_err | output | 1 | Lanes used differing write modes |
| evt_lane_err | output | 1 | A participating lane toggled mid sub-cycle |

## Verification
The bench drives scripted strobe waveforms that separate each decision the classifier makes:
- Write enable active before the column fall, or in the same sample, tells early writes from later write-enable activity.
- Output enable active or inactive at the column fall tells read-modify-write from delayed write.
- Column strobes active before the row fall, with one lane or both, tell column-before-row refresh from a column fall in the same sample as the row fall.
- Column strobes held across a second row pulse tell hidden refresh from column-before-row refresh. Releasing the row and column strobes in the same sample exercises event ordering.
- Page sequences check the page bit.
- Staggered lanes, a lane that drops and comes back, and a late lane that joins with a different write level separate legal skew from the two error kinds.

// File: rtl/dram_cls_pkg.sv
`timescale 1ns/1ps
package dram_cls_pkg;
  localparam int NUM_LANES = 2;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_READ   = 3'd1,
    K_EWR    = 3'd2,
    K_DWR    = 3'd3,
    K_RMW    = 3'd4,
    K_RONLY  = 3'd5,
    K_CBR    = 3'd6,
    K_HIDDEN = 3'd7
  } cyc_kind_t;

  typedef enum logic [1:0] {
    ROW_NONE,
    ROW_NORM,
    ROW_CBR,
    ROW_HID
  } row_mode_t;

  typedef struct packed {
    logic                 page;
    cyc_kind_t            kind;
    logic [NUM_LANES-1:0] lanes;
    logic                 lane_err;
    logic                 mode_err;
  } cls_evt_t;
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
module strobe_sync #(
  parameter int           W       = 5,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] q_n
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d_n;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_n = chain[STAGES-1];
endmodule

// File: rtl/ras_tracker.sv
`timescale 1ns/1ps
module ras_tracker
  import dram_cls_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ras,
  input  logic      ras_d,
  input  logic      cas_any,
  input  logic      cas_any_d,
  input  logic      sub_open,
  input  logic      sub_is_read,
  input  logic      sub_start,
  output logic      row_norm_now,
  output logic      page_now,
  output logic      rf_valid,
  output cyc_kind_t rf_kind
);
  row_mode_t mode;
  logic      had_cas;
  logic      hold;
  logic      ras_on, ras_off;

  assign ras_on  = ras & ~ras_d;
  assign ras_off = ~ras & ras_d;

  always_comb begin
    row_norm_now = ras && ((ras_on && !cas_any_d) || (!ras_on && mode == ROW_NORM));
    page_now     = !ras_on && had_cas;
    rf_valid     = 1'b0;
    rf_kind      = K_NONE;
    if (ras_off) begin
      case (mode)
        ROW_NORM: if (!had_cas) begin rf_valid = 1'b1; rf_kind = K_RONLY;  end
        ROW_CBR:  begin rf_valid = 1'b1; rf_kind = K_CBR;    end
        ROW_HID:  begin rf_valid = 1'b1; rf_kind = K_HIDDEN; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= ROW_NONE;
      had_cas <= 1'b0;
      hold    <= 1'b0;
    end else begin
      if (ras_on) begin
        mode    <= cas_any_d ? (hold ? ROW_HID : ROW_CBR) : ROW_NORM;
        had_cas <= sub_start;
      end else if (ras_off) begin
        mode    <= ROW_NONE;
        had_cas <= 1'b0;
      end else if (sub_start) begin
        had_cas <= 1'b1;
      end

      if (!cas_any) hold <= 1'b0;
      else if (ras_off && mode == ROW_NORM && sub_open && sub_is_read) hold <= 1'b1;
    end
  end

  // R3
  mode_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != ROW_NONE) |-> ras_d);

  // R10
  hold_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> cas_any_d);
endmodule

// File: rtl/cas_tracker.sv
`timescale 1ns/1ps
module cas_tracker
  import dram_cls_pkg::*;
#(
  parameter int LANES = NUM_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] cas,
  input  logic [LANES-1:0] cas_d,
  input  logic             we,
  input  logic             we_d,
  input  logic             oe,
  input  logic             row_norm_now,
  input  logic             page_now,
  output logic             sub_start,
  output logic             sub_open,
  output logic             sub_is_read,
  output logic             sub_valid,
  output cls_evt_t         sub_evt
);
  logic             any, any_d, sub_end, we_on;
  logic             page, we0, oe0, err_mode, err_lane;
  cyc_kind_t        kind;
  logic [LANES-1:0] lanes, done;
  logic [LANES-1:0] join_hit, rejoin_hit, lane_off;

  assign any       = |cas;
  assign any_d     = |cas_d;
  assign we_on     = we & ~we_d;
  assign sub_start = any & ~any_d & row_norm_now;
  assign sub_end   = ~any & any_d & sub_open;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic lane_on;
    assign lane_on       = cas[i] & ~cas_d[i];
    assign lane_off[i]   = ~cas[i] & cas_d[i];
    assign join_hit[i]   = sub_open & lane_on & ~lanes[i];
    assign rejoin_hit[i] = sub_open & lane_on & done[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_open <= 1'b0;
      page     <= 1'b0;
      we0      <= 1'b0;
      oe0      <= 1'b0;
      kind     <= K_NONE;
      lanes    <= '0;
      done     <= '0;
      err_mode <= 1'b0;
      err_lane <= 1'b0;
    end else if (sub_start) begin
      sub_open <= 1'b1;
      page     <= page_now;
      we0      <= we;
      oe0      <= oe;
      kind     <= we ? K_EWR : K_READ;
      lanes    <= cas;
      done     <= '0;
      err_mode <= 1'b0;
      err_lane <= 1'b0;
    end else if (sub_open) begin
      if (sub_end) begin
        sub_open <= 1'b0;
      end else begin
        if (we_on && kind == K_READ) kind <= oe0 ? K_RMW : K_DWR;
        lanes <= lanes | join_hit;
        done  <= done | lane_off;
        if (|join_hit && (we != we0)) err_mode <= 1'b1;
        if (|rejoin_hit) err_lane <= 1'b1;
      end
    end
  end

  assign sub_is_read = (kind == K_READ);
  assign sub_valid   = sub_end;
  assign sub_evt     = '{page: page, kind: kind, lanes: lanes,
                         lane_err: err_lane, mode_err: err_mode};

  // R8
  open_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_open |-> any_d);

  // R7
  kind_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_open && $past(sub_open) && $past(kind) != K_READ) |-> (kind == $past(kind)));
endmodule

// File: rtl/dram_cycle_classifier.sv
`timescale 1ns/1ps
module dram_cycle_classifier
  import dram_cls_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_n,
  input  logic                 ucas_n,
  input  logic                 lcas_n,
  input  logic                 we_n,
  input  logic                 oe_n,
  output logic                 evt_valid,
  output logic [3:0]           evt_type,
  output logic [NUM_LANES-1:0] evt_lanes,
  output logic                 evt_mode_err,
  output logic                 evt_lane_err
);
  localparam int NSTROBE = NUM_LANES + 3;

  logic [NSTROBE-1:0]   raw_n, sync_n;
  logic                 ras_a, we_a, oe_a, ras_d, we_d;
  logic [NUM_LANES-1:0] cas_a, cas_d;
  logic                 row_norm_now, page_now, rf_valid;
  logic                 sub_start, sub_open, sub_is_read, sub_valid;
  cyc_kind_t            rf_kind;
  cls_evt_t             sub_evt, rf_evt, out_q, pend_q;
  logic                 out_v, pend_v;

  assign raw_n = {ras_n, ucas_n, lcas_n, we_n, oe_n};

  strobe_sync #(.W(NSTROBE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_n(raw_n), .q_n(sync_n)
  );

  assign ras_a = ~sync_n[NSTROBE-1];
  assign cas_a = ~sync_n[NSTROBE-2:2];
  assign we_a  = ~sync_n[1];
  assign oe_a  = ~sync_n[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_d <= 1'b0;
      cas_d <= '0;
      we_d  <= 1'b0;
    end else begin
      ras_d <= ras_a;
      cas_d <= cas_a;
      we_d  <= we_a;
    end
  end

  ras_tracker u_row (
    .clk(clk), .rst_n(rst_n), .ras(ras_a), .ras_d(ras_d),
    .cas_any(|cas_a), .cas_any_d(|cas_d),
    .sub_open(sub_open), .sub_is_read(sub_is_read), .sub_start(sub_start),
    .row_norm_now(row_norm_now), .page_now(page_now),
    .rf_valid(rf_valid), .rf_kind(rf_kind)
  );

  cas_tracker #(.LANES(NUM_LANES)) u_col (
    .clk(clk), .rst_n(rst_n), .cas(cas_a), .cas_d(cas_d),
    .we(we_a), .we_d(we_d), .oe(oe_a),
    .row_norm_now(row_norm_now), .page_now(page_now),
    .sub_start(sub_start), .sub_open(sub_open), .sub_is_read(sub_is_read),
    .sub_valid(sub_valid), .sub_evt(sub_evt)
  );

  assign rf_evt = '{page: 1'b0, kind: rf_kind, lanes: '0, lane_err: 1'b0, mode_err: 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v  <= 1'b0;
      out_q  <= '0;
      pend_v <= 1'b0;
      pend_q <= '0;
    end else begin
      out_v <= rf_valid | pend_v | sub_valid;
      if (rf_valid) begin
        out_q <= rf_evt;
        if (sub_valid) begin
          pend_v <= 1'b1;
          pend_q <= sub_evt;
        end
      end else if (pend_v) begin
        out_q  <= pend_q;
        pend_v <= sub_valid;
        if (sub_valid) pend_q <= sub_evt;
      end else if (sub_valid) begin
        out_q <= sub_evt;
      end
    end
  end

  assign evt_valid    = out_v;
  assign evt_type     = out_v ? {out_q.page, out_q.kind} : 4'd0;
  assign evt_lanes    = out_v ? out_q.lanes : '0;
  assign evt_mode_err = out_v & out_q.mode_err;
  assign evt_lane_err = out_v & out_q.lane_err;

  // R1
  evt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_type[2:0] != 3'd0));

  // R3
  refresh_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_type[2:0] >= 3'd5) |->
      (evt_lanes == '0 && !evt_type[3] && !evt_mode_err && !evt_lane_err));

  // R13
  pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |=> evt_valid);
endmodule

// File: tb/dram_cycle_classifier_tb.sv
`timescale 1ns/1ps
module dram_cycle_classifier_tb_top;
  localparam int HOLD  = 3;
  localparam int WD_NS = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic       evt_valid, evt_mode_err, evt_lane_err;
  logic [3:0] evt_type;
  logic [1:0] evt_lanes;

  int    checks = 0;
  int    errors = 0;
  bit    mon_en = 1'b0;
  bit    finished = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dram_cycle_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .evt_valid(evt_valid), .evt_type(evt_type),
    .evt_lanes(evt_lanes), .evt_mode_err(evt_mode_err), .evt_lane_err(evt_lane_err)
  );

  function automatic void expect_evt(int t, int ln, int le, int me, string tag);
    exp_q.push_back((t << 4) | (ln << 2) | (le << 1) | me);
    tag_q.push_back(tag);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // raw active-low levels: row, upper, lower, write, output
  task automatic drv(logic r, logic u, logic l, logic w, logic o);
    @(negedge clk);
    ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o;
    repeat (HOLD) @(posedge clk);
  endtask

  task automatic idle();
    drv(1, 1, 1, 1, 1);
    drv(1, 1, 1, 1, 1);
  endtask

  // Reference list consumer: every event must match the next scripted entry
  always @(negedge clk) begin
    if (mon_en && evt_valid) begin
      int act;
      act = (int'(evt_type) << 4) | (int'(evt_lanes) << 2) |
            (int'(evt_lane_err) << 1) | int'(evt_mode_err);
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected event", act, 0);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(act == e, t, act, e);
      end
    end
  end

  initial begin
    #(WD_NS);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!evt_valid && evt_type == 4'd0, "R1 in reset", {evt_valid, evt_type}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!evt_valid && evt_type == 4'd0, "R1 after reset", {evt_valid, evt_type}, 0);
    mon_en = 1'b1;

    // R3 row-only refresh, with R2 latency probe
    drv(0, 1, 1, 1, 1);
    expect_evt(5, 0, 0, 0, "R3 row-only refresh");
    @(negedge clk);
    ras_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!evt_valid, "R2 not before latency", evt_valid, 0);
    @(posedge clk);
    @(negedge clk);
    check(evt_valid && evt_type == 4'd5, "R2 event at latency", {evt_valid, evt_type}, 'h15);
    idle();

    // R6 read, word
    expect_evt(1, 3, 0, 0, "R6 read word");
    drv(0, 1, 1, 1, 0); drv(0, 0, 0, 1, 0); drv(0, 1, 1, 1, 0); idle();

    // R6 early write, lower lane (R8 lane bit0)
    expect_evt(2, 1, 0, 0, "R6 early write lower");
    drv(0, 1, 1, 1, 1); drv(0, 1, 1, 0, 1); drv(0, 1, 0, 0, 1);
    drv(0, 1, 1, 0, 1); drv(0, 1, 1, 1, 1); idle();

    // R6 write enable in the same sample as the column fall, upper lane
    expect_evt(2, 2, 0, 0, "R6 early write same sample");
    drv(0, 1, 1, 1, 1); drv(0, 0, 1, 0, 1); drv(0, 1, 1, 0, 1);
    drv(0, 1, 1, 1, 1); idle();

    // R7 delayed write (output enable inactive at column fall)
    expect_evt(3, 3, 0, 0, "R7 delayed write");
    drv(0, 1, 1, 1, 1); drv(0, 0, 0, 1, 1); drv(0, 0, 0, 0, 1);
    drv(0, 1, 1, 0, 1); idle();

    // R7 read-modify-write (output enable active at column fall)
    expect_evt(4, 3, 0, 0, "R7 read-modify-write");
    drv(0, 1, 1, 1, 1); drv(0, 0, 0, 1, 0); drv(0, 0, 0, 1, 1);
    drv(0, 0, 0, 0, 1); drv(0, 1, 1, 0, 1); idle();

    // R4 column-before-row refresh, both lanes and upper lane alone
    expect_evt(6, 0, 0, 0, "R4 cbr word");
    drv(1, 0, 0, 1, 1); drv(0, 0, 0, 1, 1); drv(0, 1, 1, 1, 1); idle();
    expect_evt(6, 0, 0, 0, "R4 cbr single lane");
    drv(1, 0, 1, 1, 1); drv(0, 0, 1, 1, 1); drv(0, 1, 1, 1, 1); idle();

    // R5 row and column fall in the same sample
    expect_evt(1, 3, 0, 0, "R5 same-sample fall is access");
    drv(0, 0, 0, 1, 0); drv(0, 1, 1, 1, 0); idle();

    // R9 page sequence: read, early write, read
    expect_evt(1, 3, 0, 0, "R9 page first");
    expect_evt(10, 3, 0, 0, "R9 page second write");
    expect_evt(9, 3, 0, 0, "R9 page third read");
    drv(0, 1, 1, 1, 0); drv(0, 0, 0, 1, 0); drv(0, 1, 1, 1, 0);
    drv(0, 1, 1, 0, 1); drv(0, 0, 0, 0, 1); drv(0, 1, 1, 0, 1);
    drv(0, 1, 1, 1, 0); drv(0, 0, 0, 1, 0); drv(0, 1, 1, 1, 0); idle();

    // R10 hidden refresh
    expect_evt(7, 0, 0, 0, "R10 hidden refresh");
    expect_evt(1, 3, 0, 0, "R10 read after hidden");
    drv(0, 1, 1, 1, 0); drv(0, 0, 0, 1, 0); drv(1, 0, 0, 1, 0);
    drv(0, 0, 0, 1, 0); drv(1, 0, 0, 1, 0); idle();

    // R13 coincident row and column release
    expect_evt(7, 0, 0, 0, "R13 refresh first");
    expect_evt(1, 3, 0, 0, "R13 sub-cycle next");
    drv(0, 1, 1, 1, 0); drv(0, 0, 0, 1, 0); drv(1, 0, 0, 1, 0);
    drv(0, 0, 0, 1, 0); idle();

    // R11 late lane joins with a different write level
    expect_evt(2, 3, 0, 1, "R11 mode error");
    drv(0, 1, 1, 1, 1); drv(0, 1, 1, 0, 1); drv(0, 1, 0, 0, 1);
    drv(0, 1, 0, 1, 1); drv(0, 0, 0, 1, 1); drv(0, 1, 1, 1, 1); idle();

    // R12 lane drops and returns
    expect_evt(1, 3, 1, 0, "R12 lane error");
    drv(0, 1, 1, 1, 0); drv(0, 0, 0, 1, 0); drv(0, 0, 1, 1, 0);
    drv(0, 0, 0, 1, 0); drv(0, 1, 1, 1, 0); idle();

    // R8 legal stagger: earliest fall to latest rise, no error
    expect_evt(1, 3, 0, 0, "R8 staggered lanes");
    drv(0, 1, 1, 1, 0); drv(0, 1, 0, 1, 0); drv(0, 0, 0, 1, 0);
    drv(0, 0, 1, 1, 0); drv(0, 1, 1, 1, 0); idle();

    repeat (10) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "all scripted events seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule